// File: doc/BRIEF.md
# Byte/Halfword Insert-Extract Unit

This execution unit serves a 32-bit register machine with sixteen registers. It takes one 16-bit byte/halfword instruction together with three operand values read from the register file (the old destination value, the source value and the selector value). It produces a registered result, a register write request and a condition-code update one cycle later.

Insert operations place the low byte or low halfword of the source into one lane of the old destination value. All other destination bits are kept. Extract operations pull one lane out of the source and zero-extend it. The lane is chosen at run time by the low bits of the selector register. Register index 0 reads as constant zero wherever it names an operand, and it discards writes. Inserts leave the flags alone. Extracts always write the flags.

Top module: `bhx_unit`

## Requirements
- R1: Instruction fields: bits 7:4 hold the opcode, bits 3:0 the destination index, bits 15:12 the source index and bits 11:8 the selector index. `wr_addr_o` reports the destination index.
- R2: Opcode 4'b0111 (byte insert) writes src[7:0] into bits b+7..b of the old destination value, where b = sel[1:0]*8. Every other bit keeps its old value.
- R3: Opcode 4'b0110 (halfword insert) writes src[15:0] into bits h+15..h of the old destination value, where h = sel[1]*8*2. Selector bit 0 has no effect.
- R4: Opcode 4'b0101 (byte extract) returns src bits b+7..b in result bits 7:0, with all higher bits zero.
- R5: Opcode 4'b0100 (halfword extract) returns src bits h+15..h in result bits 15:0, with bits 31:16 zero. Selector bit 0 has no effect.
- R6: Inserts never assert `flag_we_o`.
- R7: Extracts assert `flag_we_o` with `flags_o` = {N,Z,V,C}. N, V and C are 0, and Z is 1 exactly when the result is zero.
- R8: An operand index of 0 (source, selector or old destination) supplies zero, whatever value is on the matching operand input.
- R9: An extract whose destination index is 0 makes no register write but still updates the flags.
- R10: An insert whose destination index is 0 raises `illegal_o`, with no register write and no flag write.
- R11: An opcode outside the four above leaves `valid_o` low in the following cycle.
- R12: Outputs are registered. A valid strobe in one cycle yields `valid_o` in the next. Without a strobe `valid_o`, `wr_en_o`, `flag_we_o` and `illegal_o` are low. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| dst_val_i | input | XLEN | Old value of the destination register |
| src_val_i | input | XLEN | Value of the source register |
| sel_val_i | input | XLEN | Value of the selector register |
| valid_o | output | 1 | Recognised instruction completed |
| illegal_o | output | 1 | Insert with destination index 0 |
| wr_en_o | output | 1 | Register write request |
| wr_addr_o | output | 4 | Register write index |
| result_o | output | XLEN | Result value |
| flag_we_o | output | 1 | Condition-code write enable |
| flags_o | output | 4 | {N,Z,V,C} |

## Verification
The bench builds the unit at its default XLEN of 32, so there are four byte lanes and two halfword lanes. Every lane can be selected, and each lane is set apart from its neighbours by distinct operand byte patterns. Selector values with high bits set and with bit 0 set are used to show that only the lane bits matter. Operand inputs carry nonzero values under index 0, so the zero substitution can be seen at the result.

// File: rtl/bhx_pkg.sv
package bhx_pkg;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_EXTH = 4'h4,
    OP_EXTB = 4'h5,
    OP_INSH = 4'h6,
    OP_INSB = 4'h7
  } bhx_op_e;

  typedef struct packed {
    logic known;
    logic ins;
    logic half;
    logic illegal;
    logic wr;
    logic flag_we;
  } bhx_ctl_t;
endpackage

// File: rtl/bhx_decode.sv
module bhx_decode
  import bhx_pkg::*;
(
  input  logic [15:0]      instr_i,
  output logic [IDX_W-1:0] dst_o,
  output logic [IDX_W-1:0] s1_o,
  output logic [IDX_W-1:0] s2_o,
  output bhx_ctl_t         ctl_o
);
  logic [OP_W-1:0] op;

  assign op    = instr_i[7:4];
  assign dst_o = instr_i[3:0];
  assign s1_o  = instr_i[15:12];
  assign s2_o  = instr_i[11:8];

  always_comb begin
    ctl_o = '0;
    unique case (op)
      OP_INSB: begin ctl_o.known = 1'b1; ctl_o.ins = 1'b1; end
      OP_INSH: begin ctl_o.known = 1'b1; ctl_o.ins = 1'b1; ctl_o.half = 1'b1; end
      OP_EXTB: begin ctl_o.known = 1'b1; end
      OP_EXTH: begin ctl_o.known = 1'b1; ctl_o.half = 1'b1; end
      default: ctl_o.known = 1'b0;
    endcase
    ctl_o.illegal = ctl_o.known && ctl_o.ins && (dst_o == '0);
    ctl_o.wr      = ctl_o.known && (dst_o != '0);
    ctl_o.flag_we = ctl_o.known && !ctl_o.ins;
  end
endmodule

// File: rtl/bhx_lanes.sv
module bhx_lanes #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] sel_i,
  input  logic            ins_i,
  input  logic            half_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned NB = XLEN / 8;
  localparam int unsigned NH = XLEN / 16;
  localparam int unsigned BW = $clog2(NB);
  localparam int unsigned HW = (BW > 1) ? BW - 1 : 1;

  logic [BW-1:0]   bsel;
  logic [HW-1:0]   hsel;
  logic [XLEN-1:0] ins_b, ins_h, sh_b, sh_h, ext_b, ext_h;

  assign bsel = sel_i[BW-1:0];
  assign hsel = sel_i[BW-1 -: HW];

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign ins_b[k*8 +: 8] = (bsel == BW'(k)) ? src_i[7:0] : old_i[k*8 +: 8];
  end

  for (genvar k = 0; k < NH; k++) begin : g_half
    assign ins_h[k*16 +: 16] = (hsel == HW'(k)) ? src_i[15:0] : old_i[k*16 +: 16];
  end

  assign sh_b  = src_i >> {bsel, 3'b000};
  assign sh_h  = src_i >> {hsel, 4'b0000};
  assign ext_b = {{(XLEN-8){1'b0}}, sh_b[7:0]};
  assign ext_h = {{(XLEN-16){1'b0}}, sh_h[15:0]};

  always_comb begin
    unique case ({ins_i, half_i})
      2'b11:   res_o = ins_h;
      2'b10:   res_o = ins_b;
      2'b01:   res_o = ext_h;
      default: res_o = ext_b;
    endcase
  end
endmodule

// File: rtl/bhx_unit.sv
module bhx_unit
  import bhx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [15:0]      instr_i,
  input  logic [XLEN-1:0]  dst_val_i,
  input  logic [XLEN-1:0]  src_val_i,
  input  logic [XLEN-1:0]  sel_val_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output logic [XLEN-1:0]  result_o,
  output logic             flag_we_o,
  output logic [3:0]       flags_o
);
  logic [IDX_W-1:0] dst, s1, s2;
  bhx_ctl_t         ctl;
  logic [XLEN-1:0]  old_v, src_v, sel_v, res;
  logic             go;

  bhx_decode u_dec (
    .instr_i (instr_i),
    .dst_o   (dst),
    .s1_o    (s1),
    .s2_o    (s2),
    .ctl_o   (ctl)
  );

  // index 0 reads as zero
  assign old_v = (dst == '0) ? '0 : dst_val_i;
  assign src_v = (s1  == '0) ? '0 : src_val_i;
  assign sel_v = (s2  == '0) ? '0 : sel_val_i;

  bhx_lanes #(.XLEN(XLEN)) u_lanes (
    .old_i  (old_v),
    .src_i  (src_v),
    .sel_i  (sel_v),
    .ins_i  (ctl.ins),
    .half_i (ctl.half),
    .res_o  (res)
  );

  assign go = valid_i && ctl.known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      result_o  <= '0;
      flag_we_o <= 1'b0;
      flags_o   <= '0;
    end else begin
      valid_o   <= go;
      illegal_o <= go && ctl.illegal;
      wr_en_o   <= go && ctl.wr;
      flag_we_o <= go && ctl.flag_we;
      if (go) begin
        wr_addr_o <= dst;
        result_o  <= res;
        flags_o   <= ctl.flag_we ? {1'b0, (res == '0), 2'b00} : 4'b0000;
      end
    end
  end

  // R12
  valid_in_past_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  // R12
  side_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || flag_we_o || illegal_o) |-> valid_o);
  // R9
  no_r0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o != '0));
  // R7
  ext_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (flags_o[3] == 1'b0 && flags_o[1:0] == 2'b00 && flags_o[2] == (result_o == '0)));
  // R10
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !flag_we_o));
  // R6
  ins_no_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.known && ctl.ins) |=> !flag_we_o);
endmodule

// File: tb/bhx_unit_bench.sv
module bhx_unit_bench;
  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [15:0]     instr_i = '0;
  logic [XLEN-1:0] dst_val_i = '0, src_val_i = '0, sel_val_i = '0;
  logic            valid_o, illegal_o, wr_en_o, flag_we_o;
  logic [3:0]      wr_addr_o, flags_o;
  logic [XLEN-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bhx_unit #(.XLEN(XLEN)) u_bhx_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .dst_val_i(dst_val_i), .src_val_i(src_val_i), .sel_val_i(sel_val_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .result_o(result_o), .flag_we_o(flag_we_o),
    .flags_o(flags_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model built from the requirement formulas
  function automatic logic [31:0] model(logic [3:0] op, logic [31:0] old, logic [31:0] src, logic [31:0] sel);
    int b = (sel & 3) * 8;
    int h = (sel & 2) * 8;
    case (op)
      4'h7: return (old & ~(32'hFF << b)) | ((src & 32'hFF) << b);
      4'h6: return (old & ~(32'hFFFF << h)) | ((src & 32'hFFFF) << h);
      4'h5: return (src >> b) & 32'hFF;
      default: return (src >> h) & 32'hFFFF;
    endcase
  endfunction

  // drive one instruction; check outputs one cycle later
  task automatic issue(string req, logic [3:0] op, logic [3:0] d, logic [3:0] s1, logic [3:0] s2,
                       logic [31:0] old, logic [31:0] src, logic [31:0] sel);
    logic known, ins;
    logic [31:0] e_old, e_src, e_sel, e_res;
    known = (op >= 4'h4 && op <= 4'h7);
    ins   = op[1];
    e_old = (d == 0) ? 0 : old;
    e_src = (s1 == 0) ? 0 : src;
    e_sel = (s2 == 0) ? 0 : sel;
    e_res = model(op, e_old, e_src, e_sel);
    @(negedge clk);
    valid_i = 1'b1; instr_i = {s1, s2, op, d};
    dst_val_i = old; src_val_i = src; sel_val_i = sel;
    @(negedge clk);
    valid_i = 1'b0;
    chk({req, " valid"}, valid_o, known);
    if (known) begin
      chk({req, " illegal"}, illegal_o, ins && d == 0);
      chk({req, " wr_en"}, wr_en_o, d != 0);
      chk({req, " flag_we"}, flag_we_o, !ins);
      if (d != 0) chk({req, " addr"}, wr_addr_o, d);
      if (!(ins && d == 0)) chk({req, " result"}, result_o, e_res);
      if (!ins) chk({req, " flags"}, flags_o, {1'b0, e_res == 0, 2'b00});
    end else begin
      chk({req, " wr_en"}, wr_en_o, 0);
      chk({req, " flag_we"}, flag_we_o, 0);
    end
  endtask

  task automatic t_reset();
    chk("R12 reset valid", valid_o, 0);
    chk("R12 reset result", result_o, 0);
    chk("R12 reset flags", {wr_en_o, flag_we_o, illegal_o, flags_o, wr_addr_o}, 0);
  endtask

  task automatic t_ins_byte();
    for (int k = 0; k < 4; k++)
      issue("R2 insb", 4'h7, 4'd3, 4'd5, 4'd6, 32'hA1B2C3D4, 32'h1234_5600 + k, 32'hFFFF_FFF0 | k);
    issue("R1 R2 insb fields", 4'h7, 4'd15, 4'd9, 4'd2, 32'h0, 32'hEE, 32'h2);
  endtask

  task automatic t_ins_half();
    for (int k = 0; k < 4; k++)
      issue("R3 insh", 4'h6, 4'd4, 4'd1, 4'd7, 32'h8765_4321, 32'hCAFE_BEEF, k);
  endtask

  task automatic t_ext_byte();
    for (int k = 0; k < 4; k++)
      issue("R4 extb", 4'h5, 4'd2, 4'd8, 4'd9, 32'h5555_5555, 32'h11_82_F3_04, 32'h100 | k);
  endtask

  task automatic t_ext_half();
    for (int k = 0; k < 4; k++)
      issue("R5 exth", 4'h4, 4'd6, 4'd10, 4'd11, 32'h0, 32'h9ABC_DEF0, k);
  endtask

  task automatic t_flags();
    issue("R7 extb zero", 4'h5, 4'd1, 4'd2, 4'd3, 32'hFFFF_FFFF, 32'hFF00_FFFF, 32'h2);
    issue("R7 exth nonzero", 4'h4, 4'd1, 4'd2, 4'd3, 32'h0, 32'h8000_0000, 32'h2);
    issue("R6 insh flags", 4'h6, 4'd1, 4'd2, 4'd3, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_r0();
    issue("R8 s2 zero", 4'h5, 4'd1, 4'd2, 4'd0, 32'h0, 32'hAABBCCDD, 32'h3);
    issue("R8 s1 zero", 4'h5, 4'd1, 4'd0, 4'd3, 32'h0, 32'hAABBCCDD, 32'h1);
    issue("R8 s1 zero ins", 4'h7, 4'd1, 4'd0, 4'd3, 32'h1122_3344, 32'hFF, 32'h1);
    issue("R9 ext to r0", 4'h4, 4'd0, 4'd5, 4'd0, 32'h0, 32'h0001_0000, 32'h0);
    issue("R9 ext to r0 z", 4'h5, 4'd0, 4'd5, 4'd0, 32'h0, 32'h0001_0000, 32'h0);
  endtask

  task automatic t_illegal();
    issue("R10 insb r0", 4'h7, 4'd0, 4'd5, 4'd6, 32'h1, 32'h2, 32'h3);
    issue("R10 insh r0", 4'h6, 4'd0, 4'd5, 4'd6, 32'h1, 32'h2, 32'h3);
  endtask

  task automatic t_unknown();
    issue("R11 op 0", 4'h0, 4'd1, 4'd2, 4'd3, 32'h1, 32'h2, 32'h3);
    issue("R11 op 8", 4'h8, 4'd1, 4'd2, 4'd3, 32'h1, 32'h2, 32'h3);
    issue("R11 op 3", 4'h3, 4'd1, 4'd2, 4'd3, 32'h1, 32'h2, 32'h3);
  endtask

  task automatic t_idle();
    @(negedge clk);
    instr_i = {4'd2, 4'd3, 4'h5, 4'd1}; src_val_i = 32'hFF;
    @(negedge clk);
    chk("R12 idle valid", valid_o, 0);
    chk("R12 idle wr", {wr_en_o, flag_we_o, illegal_o}, 0);
  endtask

  initial begin
    #1 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_ins_byte();
    t_ins_half();
    t_ext_byte();
    t_ext_half();
    t_flags();
    t_r0();
    t_illegal();
    t_unknown();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule